// File: doc/BRIEF.md
# Programmable Line and Frame Sync Timer

This block sets the line and frame timing of a raster pixel port. Both sync lines are active low. In master mode the block drives them itself: a pixel counter runs through a programmed line length and a line counter runs through a programmed frame length. Each sync is held low for a programmed number of pixels or lines, counted from the start of its period. In slave mode the block drives nothing on the sync lines. It samples them instead, passes each through a short synchronizer, and restarts its counters on every falling edge it sees.

In both modes the same lead and span settings place a rectangular active window inside the count space. The horizontal span is given in blocks of 8 pixels. The vertical span is given in lines. The block flags each pixel inside the window and reports its raw pixel and line positions, so a neighbouring buffer controller can compute write or read addresses.

Top module: `sync_frame_timer`

## Requirements
- R1: While `rst_n` is low, `h_pos` and `v_pos` read 0.
- R2: In master mode `h_pos` rises by one every clock and returns to 0 on the clock after it reaches `h_total`-1. With `h_total` of 0 or 1 it stays at 0.
- R3: In master mode `hsync_out_n` is 0 exactly while `h_pos` < `h_sync_len`, and 1 otherwise.
- R4: In master mode `v_pos` rises by one on each clock where `h_pos` wraps, and returns to 0 when it would reach `v_total`.
- R5: In master mode `vsync_out_n` is 0 exactly while `v_pos` < `v_sync_len`.
- R6: `pix_valid` is 1 exactly when `h_lead` <= `h_pos` < `h_lead` + 8*`h_blocks` and `v_lead` <= `v_pos` < `v_lead` + `v_lines`. With `h_blocks` = 0 it is never 1.
- R7: `sync_oe` equals `master_en`. While `master_en` is 0, both sync outputs are held at 1.
- R8: In slave mode, a 1-to-0 change on `hsync_in_n` that is held for three clocks sets `h_pos` to 0 on the third rising edge after the change. After that, `h_pos` rises by one each clock without wrapping and saturates at its maximum value of all ones.
- R9: In slave mode `v_pos` rises by one at each detected `hsync_in_n` fall. A detected `vsync_in_n` fall sets `v_pos` to 0 and takes precedence when both falls are detected together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_en | input | 1 | 1: drive the sync lines, 0: sample them |
| h_total | input | PIX_W | Pixels per line (master) |
| h_sync_len | input | PIX_W | Line sync low width in pixels (master) |
| h_lead | input | PIX_W | Pixels from line start to first active pixel |
| h_blocks | input | PIX_W-3 | Active width in 8-pixel blocks |
| v_total | input | LINE_W | Lines per frame (master) |
| v_sync_len | input | LINE_W | Frame sync low width in lines (master) |
| v_lead | input | LINE_W | Lines from frame start to first active line |
| v_lines | input | LINE_W | Active lines per frame |
| hsync_in_n | input | 1 | Sampled line sync (slave) |
| vsync_in_n | input | 1 | Sampled frame sync (slave) |
| hsync_out_n | output | 1 | Driven line sync |
| vsync_out_n | output | 1 | Driven frame sync |
| sync_oe | output | 1 | Output enable for both sync lines |
| pix_valid | output | 1 | Current pixel lies inside the active window |
| h_pos | output | PIX_W | Pixel position in the line |
| v_pos | output | LINE_W | Line position in the frame |

## Verification
The counters update on the rising edge, while the sync, window and enable outputs are decoded combinationally from the counters and settings. Master-mode results are therefore due one edge after the previous count. The bench keeps its own pixel and line model, advances it once per rising edge, and compares it against the outputs at the following falling edge. In slave mode a falling input change first crosses two synchronizer stages and then the edge detector, so the counter clears on the third rising edge. The slave tasks drive their pulses at a falling edge and wait three rising edges before they sample. The R8 and R9 checks fall on that cycle.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

  localparam int unsigned BLK_SHIFT = 3;

  // Pixels covered by a count of blocks.
  function automatic int unsigned blocks_to_pixels(input int unsigned blocks);
    return blocks << BLK_SHIFT;
  endfunction

  // True while pos lies in [start, start+len).
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned start,
                                   input int unsigned len);
    return (pos >= start) && (pos < start + len);
  endfunction

  // Active-low sync level for a sync pulse starting at position 0.
  function automatic logic sync_level_n(input int unsigned pos,
                                        input int unsigned width);
    return !(pos < width);
  endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/axis_counter.sv
module axis_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic         wrap_en,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] nxt;
  logic       at_max;

  assign nxt    = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign at_max = &cnt;
  assign wrap   = adv & wrap_en & (nxt >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr || wrap)       cnt <= '0;
    else if (adv && !at_max)    cnt <= nxt[W-1:0];
  end
endmodule

// File: rtl/sync_window.sv
module sync_window
  import sync_gen_pkg::*;
#(
  parameter int W = 11
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] sync_len,
  input  logic [W-1:0] lead,
  input  logic [W:0]   span,
  output logic         sync_n,
  output logic         active
);
  assign sync_n = sync_level_n(32'(pos), 32'(sync_len));
  assign active = in_span(32'(pos), 32'(lead), 32'(span));
endmodule

// File: rtl/sync_frame_timer.sv
module sync_frame_timer
  import sync_gen_pkg::*;
#(
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     master_en,
  input  logic [PIX_W-1:0]         h_total,
  input  logic [PIX_W-1:0]         h_sync_len,
  input  logic [PIX_W-1:0]         h_lead,
  input  logic [PIX_W-BLK_SHIFT-1:0] h_blocks,
  input  logic [LINE_W-1:0]        v_total,
  input  logic [LINE_W-1:0]        v_sync_len,
  input  logic [LINE_W-1:0]        v_lead,
  input  logic [LINE_W-1:0]        v_lines,
  input  logic                     hsync_in_n,
  input  logic                     vsync_in_n,
  output logic                     hsync_out_n,
  output logic                     vsync_out_n,
  output logic                     sync_oe,
  output logic                     pix_valid,
  output logic [PIX_W-1:0]         h_pos,
  output logic [LINE_W-1:0]        v_pos
);
  localparam int NUM_AXES = 2;

  // Named internal events, visible to the bound checker.
  logic [NUM_AXES-1:0] pin_n;
  logic [NUM_AXES-1:0] fall_evt;
  logic h_fall_evt, v_fall_evt;
  logic h_wrap_evt, v_wrap_evt;
  logic h_sync_n, v_sync_n;
  logic h_act, v_act;
  logic [PIX_W:0]  h_span;
  logic [LINE_W:0] v_span;

  assign pin_n = {vsync_in_n, hsync_in_n};

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_edge
    sync_edge_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_n(pin_n[g]),
      .fall (fall_evt[g])
    );
  end

  assign h_fall_evt = fall_evt[0];
  assign v_fall_evt = fall_evt[1];

  axis_counter #(.W(PIX_W)) u_hcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!master_en && h_fall_evt),
    .adv    (1'b1),
    .wrap_en(master_en),
    .period (h_total),
    .cnt    (h_pos),
    .wrap   (h_wrap_evt)
  );

  axis_counter #(.W(LINE_W)) u_vcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!master_en && v_fall_evt),
    .adv    (master_en ? h_wrap_evt : h_fall_evt),
    .wrap_en(master_en),
    .period (v_total),
    .cnt    (v_pos),
    .wrap   (v_wrap_evt)
  );

  assign h_span = (PIX_W+1)'(blocks_to_pixels(32'(h_blocks)));
  assign v_span = {1'b0, v_lines};

  sync_window #(.W(PIX_W)) u_hwin (
    .pos     (h_pos),
    .sync_len(h_sync_len),
    .lead    (h_lead),
    .span    (h_span),
    .sync_n  (h_sync_n),
    .active  (h_act)
  );

  sync_window #(.W(LINE_W)) u_vwin (
    .pos     (v_pos),
    .sync_len(v_sync_len),
    .lead    (v_lead),
    .span    (v_span),
    .sync_n  (v_sync_n),
    .active  (v_act)
  );

  assign sync_oe     = master_en;
  assign hsync_out_n = master_en ? h_sync_n : 1'b1;
  assign vsync_out_n = master_en ? v_sync_n : 1'b1;
  assign pix_valid   = h_act & v_act;
endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk #(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_en,
  input logic [PIX_W-1:0]  h_total,
  input logic [LINE_W-1:0] v_total,
  input logic [PIX_W-4:0]  h_blocks,
  input logic [PIX_W-1:0]  h_lead,
  input logic [LINE_W-1:0] v_lead,
  input logic              h_fall_evt,
  input logic              v_fall_evt,
  input logic              h_wrap_evt,
  input logic              v_wrap_evt,
  input logic              hsync_out_n,
  input logic              vsync_out_n,
  input logic              sync_oe,
  input logic              pix_valid,
  input logic [PIX_W-1:0]  h_pos,
  input logic [LINE_W-1:0] v_pos
);
  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && ({1'b0, h_pos} + 1'b1 < {1'b0, h_total}))
      |=> h_pos == $past(h_pos) + 1'b1);

  // R4
  v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && h_wrap_evt && ({1'b0, v_pos} + 1'b1 < {1'b0, v_total}))
      |=> v_pos == $past(v_pos) + 1'b1);

  // R4
  v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap_evt |=> v_pos == '0);

  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (!sync_oe && hsync_out_n && vsync_out_n));

  // R8
  slave_hclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && h_fall_evt) |=> h_pos == '0);

  // R9
  slave_vclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && v_fall_evt) |=> v_pos == '0);

  // R6
  window_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (h_pos >= h_lead && v_pos >= v_lead));

  // R6
  no_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_blocks == '0) |-> !pix_valid);
endmodule

bind sync_frame_timer sync_gen_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_sync_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .master_en  (master_en),
  .h_total    (h_total),
  .v_total    (v_total),
  .h_blocks   (h_blocks),
  .h_lead     (h_lead),
  .v_lead     (v_lead),
  .h_fall_evt (h_fall_evt),
  .v_fall_evt (v_fall_evt),
  .h_wrap_evt (h_wrap_evt),
  .v_wrap_evt (v_wrap_evt),
  .hsync_out_n(hsync_out_n),
  .vsync_out_n(vsync_out_n),
  .sync_oe    (sync_oe),
  .pix_valid  (pix_valid),
  .h_pos      (h_pos),
  .v_pos      (v_pos)
);

// File: tb/test_sync_frame_timer.sv
module test_sync_frame_timer;
  localparam int PIX_W  = 11;
  localparam int LINE_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b1;
  logic [PIX_W-1:0]  h_total = 20, h_sync_len = 3, h_lead = 5;
  logic [PIX_W-4:0]  h_blocks = 1;
  logic [LINE_W-1:0] v_total = 6, v_sync_len = 2, v_lead = 2, v_lines = 3;
  logic hsync_in_n = 1'b1, vsync_in_n = 1'b1;
  logic hsync_out_n, vsync_out_n, sync_oe, pix_valid;
  logic [PIX_W-1:0]  h_pos;
  logic [LINE_W-1:0] v_pos;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_frame_timer #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_sync_frame_timer (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(h_pos == 0, "R1 h_pos in reset", int'(h_pos), 0);
    check(v_pos == 0, "R1 v_pos in reset", int'(v_pos), 0);
    rst_n = 1'b1;
  endtask

  // Master-mode frame run against an independent count model.
  task automatic t_master(input int cycles);
    int eh = 0;
    int ev = 0;
    bit pv;
    master_en = 1'b1;
    do_reset();
    for (int n = 0; n < cycles; n++) begin
      pv = (eh >= int'(h_lead)) && (eh < int'(h_lead) + 8 * int'(h_blocks)) &&
           (ev >= int'(v_lead)) && (ev < int'(v_lead) + int'(v_lines));
      check(int'(h_pos) == eh, "R2 h_pos", int'(h_pos), eh);
      check(int'(v_pos) == ev, "R4 v_pos", int'(v_pos), ev);
      check(hsync_out_n == (eh >= int'(h_sync_len)), "R3 hsync_out_n",
            int'(hsync_out_n), int'(eh >= int'(h_sync_len)));
      check(vsync_out_n == (ev >= int'(v_sync_len)), "R5 vsync_out_n",
            int'(vsync_out_n), int'(ev >= int'(v_sync_len)));
      check(pix_valid == pv, "R6 pix_valid", int'(pix_valid), int'(pv));
      check(sync_oe == 1'b1, "R7 sync_oe master", int'(sync_oe), 1);
      @(posedge clk);
      if (eh + 1 >= int'(h_total)) begin
        eh = 0;
        ev = (ev + 1 >= int'(v_total)) ? 0 : ev + 1;
      end else begin
        eh++;
      end
      @(negedge clk);
    end
  endtask

  // Drive a slave sync fall at a falling edge, sample after the third rising edge.
  task automatic slave_pulse(input bit with_v);
    @(negedge clk);
    hsync_in_n = 1'b0;
    if (with_v) vsync_in_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_slave();
    master_en = 1'b0;
    do_reset();
    @(negedge clk);
    // R7
    check(sync_oe == 1'b0, "R7 sync_oe slave", int'(sync_oe), 0);
    check(hsync_out_n == 1'b1, "R7 hsync_out_n released", int'(hsync_out_n), 1);
    check(vsync_out_n == 1'b1, "R7 vsync_out_n released", int'(vsync_out_n), 1);
    repeat (7) @(negedge clk);
    // Let h_pos run past zero before the first edge
    slave_pulse(1'b0);
    check(h_pos == 0, "R8 h_pos cleared by fall", int'(h_pos), 0);
    check(v_pos == 1, "R9 v_pos step on h fall", int'(v_pos), 1);
    hsync_in_n = 1'b1;
    repeat (4) @(negedge clk);
    check(h_pos == 4, "R8 h_pos counts after fall", int'(h_pos), 4);
    slave_pulse(1'b1);
    check(h_pos == 0, "R8 h_pos cleared again", int'(h_pos), 0);
    check(v_pos == 0, "R9 vsync fall wins", int'(v_pos), 0);
    hsync_in_n = 1'b1;
    vsync_in_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      repeat (3) @(negedge clk);
      slave_pulse(1'b0);
      hsync_in_n = 1'b1;
    end
    check(v_pos == 2, "R9 v_pos after two lines", int'(v_pos), 2);
    repeat (5) @(negedge clk);
    check(h_pos == 5, "R6 slave h_pos at lead", int'(h_pos), 5);
    check(pix_valid == 1'b1, "R6 slave window start", int'(pix_valid), 1);
    repeat (8) @(negedge clk);
    check(pix_valid == 1'b0, "R6 slave window end", int'(pix_valid), 0);
    repeat (2100) @(negedge clk);
    check(h_pos == 2047, "R8 h_pos saturates", int'(h_pos), 2047);
  endtask

  task automatic t_degenerate();
    h_total  = 1;
    v_total  = 4;
    h_blocks = 0;
    master_en = 1'b1;
    do_reset();
    for (int n = 0; n < 10; n++) begin
      check(h_pos == 0, "R2 h_pos with period 1", int'(h_pos), 0);
      check(int'(v_pos) == n % 4, "R4 v_pos line per clock", int'(v_pos), n % 4);
      check(pix_valid == 1'b0, "R6 no blocks no valid", int'(pix_valid), 0);
      @(negedge clk);
    end
    h_total = 0;
    repeat (3) @(negedge clk);
    check(h_pos == 0, "R2 h_pos with period 0", int'(h_pos), 0);
    h_total  = 20;
    h_blocks = 0;
    v_total  = 6;
    t_master(130);
  endtask

  initial begin
    t_master(260);
    h_lead = 0; h_blocks = 2; v_lead = 0; v_lines = 6; h_sync_len = 0;
    t_master(130);
    h_lead = 5; h_blocks = 1; v_lead = 2; v_lines = 3; h_sync_len = 3;
    t_slave();
    t_degenerate();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule